// File: doc/BRIEF.md
# Double-Buffered Pulse Integrator with Serial Readout

This block accumulates product pulses from a correlator into a bank of integration counters on a fast correlator clock. Each counter lane takes two pulse streams. Each stream has its own one-bit prescaler, and only one of the two prescalers is allowed to toggle in any cycle. The two prescaler outputs are then merged by an exclusive-OR into a single count. A free-running divide-by-two phase decides which stream may update in a given cycle.

A dump strobe closes the current integration period. The live counts are copied into a second storage bank, and the counters restart at once. The stored snapshot is then shifted out serially on a separate, slower readout clock while the next period integrates. Toggle handshakes cross the two clock domains in both directions. One toggle starts the readout. The other returns a busy indication that stays high until the readout has finished. A dump that arrives while busy is high raises a sticky overrun flag and leaves the stored snapshot untouched.

Top module: `dbuf_integrator`

## Requirements
- R1: After reset, busy, overrun, sframe and sdata are all 0. sdata is 0 in every readout cycle in which sframe is 0.
- R2: The phase is even in the first correlator-clock cycle after reset release and alternates every cycle after that. A pulse_a bit is counted only in even cycles and a pulse_b bit only in odd cycles. A pulse in the other slot is ignored.
- R3: Each lane's count equals the number of pulses accepted since the previous dump. Pulses in a dump cycle belong to the new period.
- R4: An accepted dump (dump high while busy is low) stores all counts. The next readout frame sends them with lane 0 first and the most significant bit first, N*W bits in total. sframe is high for exactly those bits.
- R5: busy is high in the cycle after an accepted dump. It stays high for the whole readout frame and drops within a few correlator cycles after the frame ends.
- R6: A dump while busy is high sets overrun on the next cycle, and overrun stays set until reset. The stored snapshot is not overwritten, and no extra readout frame is started. The counters still restart.
- R7: Pulses that arrive during a readout are integrated into the next period.
- R8: Counts wrap modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_c | input | 1 | Correlator clock |
| rclk | input | 1 | Readout clock, slower and unrelated to clk_c |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| pulse_a | input | N | First product pulse stream, one bit per lane, counted in even cycles |
| pulse_b | input | N | Second product pulse stream, one bit per lane, counted in odd cycles |
| dump | input | 1 | End-of-integration strobe, one clk_c cycle |
| busy | output | 1 | Snapshot is waiting for or undergoing readout (clk_c domain) |
| overrun | output | 1 | Sticky flag: a dump arrived while busy |
| sdata | output | 1 | Serial readout data, changes on rclk |
| sframe | output | 1 | High while the readout word sequence is being sent |

## Verification
The count is visible in the cycle right after the edge that takes a pulse. busy and overrun settle one correlator edge after a dump. The bench therefore samples these at the next falling clk_c edge, and it updates its arithmetic count model at the same edge. A readout frame starts three to four rclk edges after an accepted dump. Because that start is not cycle-exact across the domains, the bench collects bits at falling rclk edges only while sframe is high, and compares the length and contents of the whole frame. After sframe falls, the bench allows at most ten correlator cycles for busy to drop. To show that an overrun dump does not start an extra readout, it watches for 60 further cycles and expects no new frame.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  // Stream select: 0 -> first stream (even slot), 1 -> second stream (odd slot)
  function automatic logic slot_open(input logic phase, input logic is_second);
    return phase == is_second;
  endfunction

  // Bit position inside the flattened snapshot for a lane and a bit
  function automatic int unsigned flat_pos(input int unsigned lane,
                                           input int unsigned bitn,
                                           input int unsigned width);
    return lane * width + bitn;
  endfunction
endpackage

// File: rtl/dbi_sync.sv
module dbi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbi_lane.sv
module dbi_lane
  import dbi_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         phase,
  input  logic         pa_in,
  input  logic         pb_in,
  input  logic         clr,
  output logic [W-1:0] count,
  output logic         hit
);
  logic         pre_a, pre_b;
  logic [W-2:0] upper;
  logic         acc_a, acc_b, base_a, base_b, merged;
  logic         nxt_a, nxt_b, nxt_m;
  logic [W-2:0] base_up;

  always_comb begin
    acc_a   = pa_in & slot_open(phase, 1'b0);
    acc_b   = pb_in & slot_open(phase, 1'b1);
    base_a  = clr ? 1'b0 : pre_a;
    base_b  = clr ? 1'b0 : pre_b;
    base_up = clr ? '0 : upper;
    merged  = base_a ^ base_b;
    nxt_a   = base_a ^ acc_a;
    nxt_b   = base_b ^ acc_b;
    nxt_m   = nxt_a ^ nxt_b;
    hit     = acc_a | acc_b;
  end

  // Upper stages advance on a falling edge of the merged toggle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_a <= 1'b0;
      pre_b <= 1'b0;
      upper <= '0;
    end else begin
      pre_a <= nxt_a;
      pre_b <= nxt_b;
      upper <= base_up + (W-1)'(merged & ~nxt_m);
    end
  end

  assign count = {upper, pre_a ^ pre_b};
endmodule

// File: rtl/dbi_shift.sv
module dbi_shift
  import dbi_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] snap,
  output logic           sdata,
  output logic           sframe,
  output logic           done_t
);
  localparam int WW = (N > 1) ? $clog2(N) : 1;
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int IW = $clog2(N*W);

  logic          active;
  logic [WW-1:0] word_i;
  logic [BW-1:0] bit_i;
  logic          last_bit, last_word;

  assign last_bit  = (bit_i == '0);
  assign last_word = (word_i == WW'(N-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      word_i <= '0;
      bit_i  <= '0;
      done_t <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      word_i <= '0;
      bit_i  <= BW'(W-1);
    end else if (active) begin
      if (last_bit) begin
        bit_i <= BW'(W-1);
        if (last_word) begin
          active <= 1'b0;
          done_t <= ~done_t;
        end else begin
          word_i <= word_i + 1'b1;
        end
      end else begin
        bit_i <= bit_i - 1'b1;
      end
    end
  end

  assign sframe = active;
  assign sdata  = active & snap[IW'(flat_pos(32'(word_i), 32'(bit_i), W))];
endmodule

// File: rtl/dbuf_integrator.sv
module dbuf_integrator
  import dbi_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic         clk_c,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic [N-1:0] pulse_a,
  input  logic [N-1:0] pulse_b,
  input  logic         dump,
  output logic         busy,
  output logic         overrun,
  output logic         sdata,
  output logic         sframe
);
  localparam int NB = N * W;

  // Named internal events
  logic          phase;
  logic [N-1:0]  hits;
  logic [NB-1:0] cnt_flat;
  logic [NB-1:0] snap;
  logic          take;
  logic          req_t, ack_t, ack_s;
  logic          req_s, req_d, start;

  // Integration lanes
  for (genvar i = 0; i < N; i++) begin : g_lane
    dbi_lane #(.W(W)) u_lane (
      .clk   (clk_c),
      .rst_n (rst_n),
      .phase (phase),
      .pa_in (pulse_a[i]),
      .pb_in (pulse_b[i]),
      .clr   (dump),
      .count (cnt_flat[i*W +: W]),
      .hit   (hits[i])
    );
  end

  assign busy = req_t ^ ack_s;
  assign take = dump & ~busy;

  always_ff @(posedge clk_c or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      req_t   <= 1'b0;
      snap    <= '0;
      overrun <= 1'b0;
    end else begin
      phase   <= ~phase;
      overrun <= overrun | (dump & busy);
      if (take) begin
        req_t <= ~req_t;
        snap  <= cnt_flat;
      end
    end
  end

  // Readout start: request toggle into rclk domain
  dbi_sync #(.STAGES(2)) u_req_sync (
    .clk(rclk), .rst_n(rst_n), .d(req_t), .q(req_s)
  );

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) req_d <= 1'b0;
    else        req_d <= req_s;
  end

  assign start = req_s ^ req_d;

  dbi_shift #(.N(N), .W(W)) u_shift (
    .clk    (rclk),
    .rst_n  (rst_n),
    .start  (start),
    .snap   (snap),
    .sdata  (sdata),
    .sframe (sframe),
    .done_t (ack_t)
  );

  // Completion toggle back into clk_c domain
  dbi_sync #(.STAGES(2)) u_ack_sync (
    .clk(clk_c), .rst_n(rst_n), .d(ack_t), .q(ack_s)
  );
endmodule

// File: rtl/dbuf_integrator_chk.sv
module dbuf_integrator_chk #(
  parameter int N = 8,
  parameter int W = 16
) (
  input logic           clk_c,
  input logic           rclk,
  input logic           rst_n,
  input logic           dump,
  input logic           busy,
  input logic           overrun,
  input logic           phase,
  input logic [N-1:0]   hits,
  input logic [N*W-1:0] cnt_flat,
  input logic [N*W-1:0] snap,
  input logic           sdata,
  input logic           sframe
);
  // R2
  phase_rise_chk: assert property (@(posedge clk_c) disable iff (!rst_n)
    !phase |=> phase);
  // R2
  phase_fall_chk: assert property (@(posedge clk_c) disable iff (!rst_n)
    phase |=> !phase);
  // R5
  busy_set_chk: assert property (@(posedge clk_c) disable iff (!rst_n)
    (dump && !busy) |=> busy);
  // R6
  overrun_set_chk: assert property (@(posedge clk_c) disable iff (!rst_n)
    (dump && busy) |=> overrun);
  // R6
  overrun_sticky_chk: assert property (@(posedge clk_c) disable iff (!rst_n)
    overrun |=> overrun);
  // R4
  snap_load_chk: assert property (@(posedge clk_c) disable iff (!rst_n)
    (dump && !busy) |=> snap == $past(cnt_flat));
  // R6
  snap_hold_chk: assert property (@(posedge clk_c) disable iff (!rst_n)
    !(dump && !busy) |=> $stable(snap));
  // R1
  idle_low_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !sframe |-> !sdata);

  for (genvar i = 0; i < N; i++) begin : g_l
    // R3
    count_step_chk: assert property (@(posedge clk_c) disable iff (!rst_n)
      !dump |=> (cnt_flat[i*W +: W] - $past(cnt_flat[i*W +: W])) == W'($past(hits[i])));
    // R3
    count_restart_chk: assert property (@(posedge clk_c) disable iff (!rst_n)
      dump |=> cnt_flat[i*W +: W] == W'($past(hits[i])));
  end
endmodule

bind dbuf_integrator dbuf_integrator_chk #(.N(N), .W(W)) u_chk (
  .clk_c    (clk_c),
  .rclk     (rclk),
  .rst_n    (rst_n),
  .dump     (dump),
  .busy     (busy),
  .overrun  (overrun),
  .phase    (phase),
  .hits     (hits),
  .cnt_flat (cnt_flat),
  .snap     (snap),
  .sdata    (sdata),
  .sframe   (sframe)
);

// File: tb/sim_dbuf_integrator.sv
`timescale 1ns/100ps
module sim_dbuf_integrator;
  localparam int N    = 3;
  localparam int W    = 5;
  localparam int NB   = N * W;
  localparam int MASK = (1 << W) - 1;

  logic         clk_c = 1'b0;
  logic         rclk  = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pa = '0;
  logic [N-1:0] pb = '0;
  logic         dump = 1'b0;
  logic         busy, overrun, sdata, sframe;

  always #5    clk_c = ~clk_c;
  always #18.5 rclk  = ~rclk;

  dbuf_integrator #(.N(N), .W(W)) u0 (
    .clk_c(clk_c), .rclk(rclk), .rst_n(rst_n),
    .pulse_a(pa), .pulse_b(pb), .dump(dump),
    .busy(busy), .overrun(overrun), .sdata(sdata), .sframe(sframe)
  );

  int checks = 0, failures = 0;
  int k = 0;
  int cnt [N];
  int exp_snap [N];
  int cap [N];
  int got [N];
  int cap_len = 0, got_len = 0, frames_done = 0, idle_bad = 0;
  logic prev_fr = 1'b0;

  // Frame collector on the readout clock
  always @(negedge rclk) begin
    if (sframe) begin
      if (cap_len < NB)
        cap[cap_len / W] = cap[cap_len / W] | (int'(sdata) << (W - 1 - cap_len % W));
      cap_len++;
    end else begin
      if (sdata) idle_bad++;
      if (prev_fr) begin
        for (int i = 0; i < N; i++) begin
          got[i] = cap[i];
          cap[i] = 0;
        end
        got_len = cap_len;
        cap_len = 0;
        frames_done++;
      end
    end
    prev_fr = sframe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int ex);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, ex);
    end
  endtask

  function automatic logic [N-1:0] pat(input int kk, input int s);
    return N'(((kk * s) + (kk >> 2) + s) ^ (kk * 3));
  endfunction

  // One correlator cycle; model per R2/R3/R6
  task automatic cyc(input logic [N-1:0] a, input logic [N-1:0] b, input logic d);
    bit acc;
    pa = a; pb = b; dump = d;
    acc = d && !busy;
    @(posedge clk_c);
    for (int i = 0; i < N; i++) begin
      int c;
      c = (k % 2 == 0) ? int'(a[i]) : int'(b[i]);
      if (d) begin
        if (acc) exp_snap[i] = cnt[i];
        cnt[i] = c;
      end else begin
        cnt[i] = (cnt[i] + c) & MASK;
      end
    end
    k++;
    @(negedge clk_c);
    pa = '0; pb = '0; dump = 1'b0;
    if (d && acc)  chk(busy == 1'b1, "R5 busy after accepted dump", int'(busy), 1);
    if (d && !acc) chk(overrun == 1'b1, "R6 overrun after dump while busy", int'(overrun), 1);
  endtask

  task automatic run(input int n, input int s);
    for (int j = 0; j < n; j++) cyc(pat(k, s), pat(k, s + 4), 1'b0);
  endtask

  // Wait for the next frame while integrating (R7), then compare
  task automatic read_check(input string tag, input int s);
    int fd0, n, bad;
    fd0 = frames_done; n = 0; bad = 0;
    while (frames_done == fd0 && n < 600) begin
      cyc(pat(k, s), pat(k, s + 1), 1'b0);
      if (sframe && !busy) bad++;
      n++;
    end
    chk(frames_done != fd0, {tag, " frame seen"}, frames_done - fd0, 1);
    chk(bad == 0, "R5 busy held during frame", bad, 0);
    chk(got_len == NB, "R4 frame length", got_len, NB);
    for (int i = 0; i < N; i++)
      chk(got[i] == exp_snap[i], {tag, " word"}, got[i], exp_snap[i]);
    n = 0;
    while (busy && n < 10) begin
      cyc(pat(k, s), pat(k, s + 1), 1'b0);
      n++;
    end
    chk(!busy, "R5 busy clears after frame", int'(busy), 0);
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int fd;
    for (int i = 0; i < N; i++) begin
      cnt[i] = 0; exp_snap[i] = 0; cap[i] = 0; got[i] = 0;
    end
    repeat (3) @(negedge clk_c);
    rst_n = 1'b1;
    // R1 reset state
    chk(busy == 1'b0,    "R1 busy at reset",    int'(busy), 0);
    chk(overrun == 1'b0, "R1 overrun at reset", int'(overrun), 0);
    chk(sframe == 1'b0,  "R1 sframe at reset",  int'(sframe), 0);
    chk(sdata == 1'b0,   "R1 sdata at reset",   int'(sdata), 0);

    // R2: first stream every cycle, only even slots count
    for (int j = 0; j < 12; j++) cyc('1, '0, 1'b0);
    cyc('0, '0, 1'b1);
    for (int i = 0; i < N; i++) chk(exp_snap[i] == 6, "R2 even-slot count model", exp_snap[i], 6);
    read_check("R2 first stream", 2);

    // R2: second stream only, odd slots
    cyc('0, '0, 1'b1);
    for (int j = 0; j < 13; j++) cyc('0, '1, 1'b0);
    cyc('0, '0, 1'b1);
    read_check("R2 second stream", 3);

    // R3/R7 mixed patterns of several lengths
    for (int s = 1; s <= 3; s++) begin
      run(10 * s + 7, s);
      cyc(pat(k, s + 7), pat(k, s + 8), 1'b1);
      read_check("R3 R7 pattern", s + 5);
    end

    // R3: dump cycle carrying pulses starts the new period
    cyc('1, '1, 1'b1);
    read_check("R3 dump pulse", 1);
    run(9, 6);
    cyc('0, '0, 1'b1);
    read_check("R3 after dump pulse", 4);

    // R8: wrap past 2^W
    for (int j = 0; j < 70; j++) cyc('1, '1, 1'b0);
    cyc('0, '0, 1'b1);
    read_check("R8 wrap", 7);

    // R6: overrun keeps snapshot and starts no extra frame
    run(15, 2);
    cyc('1, '0, 1'b1);
    run(3, 3);
    cyc('1, '1, 1'b1);
    read_check("R6 old data kept", 5);
    fd = frames_done;
    run(60, 1);
    chk(frames_done == fd, "R6 no extra frame", frames_done - fd, 0);
    chk(overrun == 1'b1, "R6 overrun sticky", int'(overrun), 1);
    cyc('0, '0, 1'b1);
    read_check("R6 period after overrun", 6);

    chk(idle_bad == 0, "R1 sdata low outside frame", idle_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule